// File: doc/BRIEF.md
# AUX Transaction Retry Sequencer

This block runs one request/reply exchange over a display auxiliary channel. The channel has a control/status side and five 32-bit data words, and its serial engine lives outside this block. After a start pulse the sequencer checks that the channel is idle and that the byte counts fit. It then works through a list of bit-clock divider candidates. Each candidate gets a fixed number of send attempts, and each attempt loads the data words and then fires the channel. When an attempt ends, the sequencer clears the channel's sticky status bits. The outcome decides what happens next: retry at once, back off, or stop. When the retries are over, it turns the last captured status into one result code and a received-byte count.

All waiting is done in system clock cycles. The clock rate is given in kHz through `CLK_KHZ`. One transaction is handled at a time. The result code and count stay on the outputs from one `res_valid` pulse until the next transaction finishes.

Top module: `aux_retry_seq`

## Requirements
- R1: While reset is held and just after release, `load_data`, `send_go`, `clr_sticky` and `res_valid` are low, and `result` and `rx_count` are 0.
- R2: After start, `ch_busy` is sampled up to three times, `CLK_KHZ` cycles apart (one read every `CLK_KHZ`+1 cycles). If all three reads show busy, the block finishes with result 1 (busy) and issues no `send_go`. With the busy flag stuck high, `res_valid` rises 2+2*(`CLK_KHZ`+1) cycles after the start cycle.
- R3: If `send_len` or `recv_len` is above 20, the block finishes with result 2 (oversize) and issues no `send_go`.
- R4: Candidate k has divider value round(REF_KHZ[k]/2000), computed as (f+1000)/2000. Candidates are used in index order. A candidate of value zero, or the end of the list, stops the retries. `divider` holds the value of the current candidate at each `send_go`.
- R5: Each candidate gets up to 5 attempts. An attempt is a one-cycle `load_data` followed in the next cycle by a one-cycle `send_go`.
- R6: After `send_go` the block waits for `ch_busy` to drop, or for at most 10*`CLK_KHZ` cycles. `clr_sticky` then pulses 10*`CLK_KHZ`+1 cycles after a `send_go` whose busy never clears.
- R7: Every attempt ends with exactly one `clr_sticky` pulse, which tells the channel to clear its done, timeout and receive-error bits.
- R8: A timeout-flagged attempt is followed by the next `load_data` one cycle after `clr_sticky`. A receive-error attempt (without timeout) waits ceil(0.4*`CLK_KHZ`) further cycles, so the next `load_data` comes 1+ceil(0.4*`CLK_KHZ`) cycles after `clr_sticky`. Done with neither error ends the retries.
- R9: Once the retries end, the final status is classified in this order: done never set gives result 1 (busy), receive error gives result 3 (I/O error), timeout gives result 4 (timeout).
- R10: Otherwise a received size of 0 or above 20 gives result 1. Any other size gives result 0 (success) with `rx_count` = min(size, `recv_len`). `rx_count` is 0 for every result other than success.
- R11: `res_valid` is a one-cycle pulse. `result` and `rx_count` change only together with it. A start pulse that arrives while a transaction is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a transaction (accepted only when idle) |
| send_len | input | LEN_W | Bytes to send |
| recv_len | input | LEN_W | Receive buffer size in bytes |
| ch_busy | input | 1 | Channel busy flag |
| ch_done | input | 1 | Channel sticky done bit |
| ch_tmo | input | 1 | Channel sticky timeout-error bit |
| ch_rxerr | input | 1 | Channel sticky receive-error bit |
| ch_rx_size | input | LEN_W | Byte count the channel received |
| load_data | output | 1 | Load the data words for this attempt |
| send_go | output | 1 | Start command to the channel |
| clr_sticky | output | 1 | Clear the channel's done and error bits |
| divider | output | DIV_W | Bit-clock divider for the current candidate |
| res_valid | output | 1 | One-cycle pulse: result is new |
| result | output | 3 | 0 ok, 1 busy, 2 oversize, 3 I/O error, 4 timeout |
| rx_count | output | LEN_W | Received bytes delivered |

## Verification
The assertions take four things for granted about the channel. It raises `ch_busy` in the cycle after `send_go` and keeps it high until the attempt ends. It holds done and both error bits until `clr_sticky`. It never reports a received size wider than the port. It never asks for a start while idle and busy at once from a stuck previous transfer unless that case is being tested. The channel model in the bench follows all of this. It raises busy one cycle after `send_go` and drops it a few cycles later together with done and the scripted error bits. In the hang case it keeps busy high and drops it only on `clr_sticky`. The stuck-idle cases are made by a separate pre-start busy window that the bench opens and closes between transactions.

// File: rtl/aux_retry_seq.sv
module aux_retry_seq #(
  parameter int CLK_KHZ   = 125000,
  parameter int NUM_CAND  = 2,
  parameter int DIV_W     = 8,
  parameter int MAX_BYTES = 20,
  parameter int ATTEMPTS  = 5,
  parameter int POLL_TRIES = 3,
  parameter logic [NUM_CAND*32-1:0] REF_KHZ = {32'd24000, 32'd19200},
  localparam int LEN_W = $clog2(MAX_BYTES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [LEN_W-1:0] send_len,
  input  logic [LEN_W-1:0] recv_len,
  input  logic             ch_busy,
  input  logic             ch_done,
  input  logic             ch_tmo,
  input  logic             ch_rxerr,
  input  logic [LEN_W-1:0] ch_rx_size,
  output logic             load_data,
  output logic             send_go,
  output logic             clr_sticky,
  output logic [DIV_W-1:0] divider,
  output logic             res_valid,
  output logic [2:0]       result,
  output logic [LEN_W-1:0] rx_count
);
  localparam int POLL_GAP = CLK_KHZ;
  localparam int WAIT_CYC = CLK_KHZ * 10;
  localparam int BACKOFF  = (CLK_KHZ * 400 + 999) / 1000;
  localparam int TMR_W    = $clog2(WAIT_CYC + 1);
  localparam int CI_W     = $clog2(NUM_CAND + 1);
  localparam int AT_W     = $clog2(ATTEMPTS + 1);
  localparam int PT_W     = $clog2(POLL_TRIES + 1);
  localparam logic [2:0] RES_OK = 3'd0, RES_BUSY = 3'd1, RES_BIG = 3'd2,
                         RES_IO = 3'd3, RES_TMO = 3'd4;
  localparam logic [LEN_W-1:0] LIM = LEN_W'(MAX_BYTES);

  typedef enum logic [3:0] {
    S_IDLE, S_POLL, S_GAP, S_CHECK, S_PICK, S_LOAD, S_GO, S_WAIT, S_CLEAR, S_BACK, S_EVAL
  } st_t;

  st_t              st;
  logic [TMR_W-1:0] tmr;
  logic [PT_W-1:0]  tries;
  logic [AT_W-1:0]  att;
  logic [CI_W-1:0]  cidx;
  logic [LEN_W-1:0] slen_q, rlen_q, size_q;
  logic             done_q, tmo_q, rx_q;

  function automatic logic [DIV_W-1:0] cand(input logic [CI_W-1:0] i);
    logic [31:0] f;
    f = 32'd0;
    for (int k = 0; k < NUM_CAND; k++)
      if (k == int'(i)) f = REF_KHZ[k*32 +: 32];
    return DIV_W'((f + 32'd1000) / 32'd2000);
  endfunction

  assign load_data  = (st == S_LOAD);
  assign send_go    = (st == S_GO);
  assign clr_sticky = (st == S_CLEAR);

  wire last_att = (att == AT_W'(ATTEMPTS - 1));
  wire [LEN_W-1:0] trunc = (size_q > rlen_q) ? rlen_q : size_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; tmr <= '0; tries <= '0; att <= '0; cidx <= '0;
      slen_q <= '0; rlen_q <= '0; size_q <= '0;
      done_q <= 1'b0; tmo_q <= 1'b0; rx_q <= 1'b0;
      divider <= '0; res_valid <= 1'b0; result <= RES_OK; rx_count <= '0;
    end else begin
      res_valid <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          tries <= '0; slen_q <= send_len; rlen_q <= recv_len; st <= S_POLL;
        end
        S_POLL: begin
          if (!ch_busy) st <= S_CHECK;
          else if (tries == PT_W'(POLL_TRIES - 1)) begin
            res_valid <= 1'b1; result <= RES_BUSY; rx_count <= '0; st <= S_IDLE;
          end else begin
            tries <= tries + 1'b1; tmr <= '0; st <= S_GAP;
          end
        end
        S_GAP: if (tmr == TMR_W'(POLL_GAP - 1)) st <= S_POLL;
               else tmr <= tmr + 1'b1;
        S_CHECK: begin
          if (slen_q > LIM || rlen_q > LIM) begin
            res_valid <= 1'b1; result <= RES_BIG; rx_count <= '0; st <= S_IDLE;
          end else begin
            cidx <= '0; done_q <= 1'b0; tmo_q <= 1'b0; rx_q <= 1'b0; st <= S_PICK;
          end
        end
        S_PICK: begin
          if (cidx == CI_W'(NUM_CAND) || cand(cidx) == '0) st <= S_EVAL;
          else begin divider <= cand(cidx); att <= '0; st <= S_LOAD; end
        end
        S_LOAD: st <= S_GO;
        S_GO: begin tmr <= '0; st <= S_WAIT; end
        S_WAIT: begin
          if (!ch_busy || tmr == TMR_W'(WAIT_CYC - 1)) begin
            done_q <= ch_done; tmo_q <= ch_tmo; rx_q <= ch_rxerr; size_q <= ch_rx_size;
            st <= S_CLEAR;
          end else tmr <= tmr + 1'b1;
        end
        S_CLEAR: begin
          if (rx_q && !tmo_q) begin tmr <= '0; st <= S_BACK; end
          else if (done_q && !tmo_q) st <= S_EVAL;
          else if (last_att) begin cidx <= cidx + 1'b1; st <= S_PICK; end
          else begin att <= att + 1'b1; st <= S_LOAD; end
        end
        S_BACK: begin
          if (tmr == TMR_W'(BACKOFF - 1)) begin
            if (last_att) begin cidx <= cidx + 1'b1; st <= S_PICK; end
            else begin att <= att + 1'b1; st <= S_LOAD; end
          end else tmr <= tmr + 1'b1;
        end
        S_EVAL: begin
          res_valid <= 1'b1; st <= S_IDLE; rx_count <= '0;
          if (!done_q) result <= RES_BUSY;
          else if (rx_q) result <= RES_IO;
          else if (tmo_q) result <= RES_TMO;
          else if (size_q == '0 || size_q > LIM) result <= RES_BUSY;
          else begin result <= RES_OK; rx_count <= trunc; end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  a_r5_go_after_load: assert property (@(posedge clk) disable iff (!rst_n)
    send_go |-> $past(load_data));
  a_r4_div_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    send_go |-> divider != '0);
  a_r11_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid);
  a_r11_hold_result: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |-> ($stable(result) && $stable(rx_count)));
  a_r10_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && result == RES_OK) |-> (rx_count != '0 && rx_count <= rlen_q));
endmodule

// File: tb/aux_retry_seq_bench.sv
module aux_retry_seq_bench;
  localparam int CLK_KHZ  = 10;
  localparam int WAIT_CYC = CLK_KHZ * 10;
  localparam int BACKOFF  = (CLK_KHZ * 400 + 999) / 1000;
  localparam int POLL_GAP = CLK_KHZ;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n = 1'b0, start = 1'b0;
  logic [4:0] send_len = '0, recv_len = '0;
  logic ch_busy, load_data, send_go, clr_sticky, res_valid;
  logic [7:0] divider;
  logic [2:0] result;
  logic [4:0] rx_count;

  int mcyc = 0, pre_until = 0, m_att = 0, lat = 0;
  logic abusy = 1'b0, m_done = 1'b0, m_tmo = 1'b0, m_rxe = 1'b0;
  logic [4:0] m_size = '0, cfg_size = '0;
  logic [1:0] cur_kind = '0, cfg_kind = '0;
  int cfg_nfail = 0;

  assign ch_busy = abusy || (mcyc < pre_until);

  aux_retry_seq #(.CLK_KHZ(CLK_KHZ), .NUM_CAND(3),
                  .REF_KHZ({32'd0, 32'd143000, 32'd125000})) u_aux_retry_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .send_len(send_len), .recv_len(recv_len),
    .ch_busy(ch_busy), .ch_done(m_done), .ch_tmo(m_tmo), .ch_rxerr(m_rxe),
    .ch_rx_size(m_size), .load_data(load_data), .send_go(send_go),
    .clr_sticky(clr_sticky), .divider(divider), .res_valid(res_valid),
    .result(result), .rx_count(rx_count));

  // channel model: kind 0 ok, 1 timeout, 2 receive error, 3 hang
  always @(posedge clk) begin
    mcyc <= mcyc + 1;
    if (start) m_att <= 0;
    if (send_go) begin
      abusy <= 1'b1; lat <= 3; m_att <= m_att + 1;
      cur_kind <= (m_att < cfg_nfail) ? cfg_kind : 2'd0;
    end else if (clr_sticky) begin
      abusy <= 1'b0; m_done <= 1'b0; m_tmo <= 1'b0; m_rxe <= 1'b0;
    end else if (abusy && cur_kind != 2'd3) begin
      if (lat == 0) begin
        abusy <= 1'b0; m_done <= 1'b1; m_size <= cfg_size;
        m_tmo <= (cur_kind == 2'd1); m_rxe <= (cur_kind == 2'd2);
      end else lat <= lat - 1;
    end
  end

  int gos = 0, nres = 0, go_cyc = 0, clr_cyc = 0, go2clr = 0, gap = 0;
  int div_at [0:15];
  always @(posedge clk) begin
    if (start) begin gos <= 0; nres <= 0; gap <= 0; end
    else begin
      if (send_go) begin
        gos <= gos + 1; go_cyc <= mcyc;
        if (gos < 15) div_at[gos + 1] <= int'(divider);
      end
      if (clr_sticky) begin go2clr <= mcyc - go_cyc; clr_cyc <= mcyc; end
      if (load_data && gos > 0) gap <= mcyc - clr_cyc;
      if (res_valid) nres <= nres + 1;
    end
  end

  int nchk = 0, nbad = 0, last_lat = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // {send, recv, kind, nfail, size, pre, exp_result, exp_count, exp_gos, exp_gap}
  localparam int NV = 15;
  localparam logic [45:0] VEC [NV] = '{
    {5'd4, 5'd2, 2'd0, 4'd0, 5'd2, 10'd0, 3'd0, 5'd2, 4'd1, 3'd0},
    {5'd4, 5'd3, 2'd0, 4'd0, 5'd5, 10'd0, 3'd0, 5'd3, 4'd1, 3'd0},
    {5'd4, 5'd2, 2'd0, 4'd0, 5'd0, 10'd0, 3'd1, 5'd0, 4'd1, 3'd0},
    {5'd4, 5'd2, 2'd0, 4'd0, 5'd21, 10'd0, 3'd1, 5'd0, 4'd1, 3'd0},
    {5'd21, 5'd2, 2'd0, 4'd0, 5'd2, 10'd0, 3'd2, 5'd0, 4'd0, 3'd0},
    {5'd4, 5'd21, 2'd0, 4'd0, 5'd2, 10'd0, 3'd2, 5'd0, 4'd0, 3'd0},
    {5'd20, 5'd20, 2'd0, 4'd0, 5'd20, 10'd0, 3'd0, 5'd20, 4'd1, 3'd0},
    {5'd4, 5'd4, 2'd1, 4'd2, 5'd4, 10'd0, 3'd0, 5'd4, 4'd3, 3'd1},
    {5'd4, 5'd4, 2'd2, 4'd1, 5'd4, 10'd0, 3'd0, 5'd4, 4'd2, 3'd5},
    {5'd4, 5'd4, 2'd1, 4'd15, 5'd4, 10'd0, 3'd4, 5'd0, 4'd10, 3'd1},
    {5'd4, 5'd4, 2'd2, 4'd15, 5'd4, 10'd0, 3'd3, 5'd0, 4'd10, 3'd5},
    {5'd4, 5'd4, 2'd3, 4'd15, 5'd4, 10'd0, 3'd1, 5'd0, 4'd10, 3'd0},
    {5'd4, 5'd2, 2'd0, 4'd0, 5'd2, 10'd1000, 3'd1, 5'd0, 4'd0, 3'd0},
    {5'd4, 5'd2, 2'd0, 4'd0, 5'd2, 10'd15, 3'd0, 5'd2, 4'd1, 3'd0},
    {5'd4, 5'd4, 2'd1, 4'd7, 5'd4, 10'd0, 3'd0, 5'd4, 4'd8, 3'd1}
  };

  task automatic run_one(input int pre);
    int n;
    @(negedge clk);
    pre_until = mcyc + pre;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    n = 1;
    while (!res_valid && n < 6000) begin @(negedge clk); n++; end
    last_lat = n;
    @(negedge clk);
    pre_until = 0;
  endtask

  logic [45:0] v;

  initial begin
    repeat (3) @(negedge clk);
    chk(!load_data && !send_go && !clr_sticky && !res_valid, "R1 pulses in reset",
        int'({load_data, send_go, clr_sticky, res_valid}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(result == 3'd0 && rx_count == 5'd0 && !res_valid, "R1 state after reset",
        int'({result, rx_count}), 0);

    for (int i = 0; i < NV; i++) begin
      v = VEC[i];
      send_len = v[45:41]; recv_len = v[40:36];
      cfg_kind = v[35:34]; cfg_nfail = int'(v[33:30]); cfg_size = v[29:25];
      run_one(int'(v[24:15]));
      chk(result == v[14:12], $sformatf("R9 R10 R3 R2 result vec %0d", i),
          int'(result), int'(v[14:12]));
      chk(rx_count == v[11:7], $sformatf("R10 rx_count vec %0d", i),
          int'(rx_count), int'(v[11:7]));
      chk(gos == int'(v[6:3]), $sformatf("R5 attempts vec %0d", i), gos, int'(v[6:3]));
      if (v[2:0] != 3'd0)
        chk(gap == int'(v[2:0]), $sformatf("R8 clear-to-load gap vec %0d", i),
            gap, int'(v[2:0]));
      if (i == 11)
        chk(go2clr == WAIT_CYC + 1, "R6 wait limit", go2clr, WAIT_CYC + 1);
      if (i == 11)
        chk(nres == 1, "R7 R11 one result", nres, 1);
      if (i == 12)
        chk(last_lat == 2 + 2 * (POLL_GAP + 1), "R2 poll latency", last_lat,
            2 + 2 * (POLL_GAP + 1));
      if (i == 14) begin
        chk(div_at[1] == 63, "R4 first divider", div_at[1], 63);
        chk(div_at[6] == 72, "R4 second divider rounded", div_at[6], 72);
      end
      if (i == 10)
        chk(BACKOFF == 4, "R8 backoff constant", BACKOFF, 4);
    end

    // R11: a start during a transaction is ignored
    send_len = 5'd4; recv_len = 5'd2; cfg_kind = 2'd0; cfg_nfail = 0; cfg_size = 5'd2;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (300) @(negedge clk);
    chk(nres == 1, "R11 second start ignored", nres, 1);
    chk(gos == 1, "R11 single attempt", gos, 1);
    chk(result == 3'd0 && rx_count == 5'd2, "R11 result held", int'(rx_count), 2);

    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      nchk++; nbad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
      $finish;
    end
  end
endmodule